// File: doc/BRIEF.md
# History-Selected Two-Bank One-Bit Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps two banks of one-bit entries and one bit of global history. The history bit holds the actual direction of the most recently resolved branch, whatever that branch was. On every lookup and every update, that bit chooses which bank is used. The other bank is neither read nor written. Inside the chosen bank, a few low bits of the branch address above the byte offset pick one entry. That entry repeats the outcome it last recorded.

The lookup side is purely combinational: an address goes in and a taken/not-taken guess comes out in the same cycle. The resolve side takes an address and the real outcome, qualified by a valid strobe. It writes the bank chosen by the history bit as it stood before the update, and then loads that outcome into the history bit. Both changes take effect on the next rising clock edge, so the very next lookup sees them. A mode input can pin all traffic to bank zero, which turns the block into a plain one-bit predictor.

Top module: `gsel_dir_predictor`

## Requirements
- R1: After reset, every entry in both banks and the history bit are 0 (not taken), so the prediction is 0 for every address.
- R2: The prediction equals the outcome last written to the addressed entry of the selected bank. Output 1 means taken and 0 means not taken.
- R3: After each resolve, the history bit equals the actual outcome of that resolve. This holds whether or not it is the branch currently being predicted.
- R4: When the history bit is 0 a lookup reads bank 0, and when it is 1 it reads bank 1. The other bank never affects the prediction.
- R5: A resolve writes only the bank chosen by the history bit. The entry at the same index in the other bank keeps its value.
- R6: A resolve picks its bank with the history bit as it was before that resolve. The history bit is then loaded with the new outcome.
- R7: The entry index is address bits [log2(ENTRIES)+1:2], which is bits [5:2] for the default of 16 entries per bank. Bits [1:0] and the bits above the index are ignored, so such addresses alias.
- R8: The prediction is combinational from the lookup address and the current state. A resolve takes effect on the rising clock edge where res_valid is 1, and is visible to a lookup in the very next cycle. While res_valid is 0, neither the banks nor the history bit change.
- R9: While solo_mode is 1, lookups and resolves both use bank 0 whatever the history bit holds. The history bit still records each resolved outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| solo_mode | input | 1 | 1: ignore the history bit and use bank 0 only |
| pred_addr | input | ADDR_W | Address of the branch being looked up |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| res_valid | input | 1 | Resolve strobe |
| res_addr | input | ADDR_W | Address of the resolved branch |
| res_taken | input | 1 | Actual direction of the resolved branch |

## Verification
A prediction is due in the same cycle as its address, with no register on the path. The bench sets the lookup address just after a falling edge and samples pred_taken one time unit later. A resolve is driven at a falling edge and is committed at the following rising edge. Its effect on a lookup is due from that edge on, so the bench drops the strobe at the next falling edge and only then looks up and compares. Sequences are built so that the bank that was written and the bank that is later read differ whenever a wrong selection or a wrong update order would change the value returned.

// File: rtl/gsel_pkg.sv
package gsel_pkg;

   typedef enum logic {
      BANK_AFTER_NT = 1'b0,
      BANK_AFTER_T  = 1'b1
   } bank_e;

   localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/gsel_bit_bank.sv
module gsel_bit_bank #(
   parameter int unsigned ENTRIES = 16,
   localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_bit,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_bit
);

   logic [ENTRIES-1:0] cells;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cells <= '0;
      end else if (wr_en) begin
         cells[wr_idx] <= wr_bit;
      end
   end

   assign rd_bit = cells[rd_idx];

   // R8: a write lands in the addressed cell on the next edge
   a_r8_write_lands : assert property (@(posedge clk) disable iff (!rst_n)
      rst_n && wr_en |=> cells[$past(wr_idx)] == $past(wr_bit));

   // R5: an unselected bank holds all of its cells
   a_r5_idle_bank_holds : assert property (@(posedge clk) disable iff (!rst_n)
      rst_n && !wr_en |=> $stable(cells));

endmodule

// File: rtl/gsel_hist_bit.sv
module gsel_hist_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic outcome,
   output logic last_taken
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_taken <= 1'b0;
      end else if (load) begin
         last_taken <= outcome;
      end
   end

   // R3: history follows the last resolved outcome
   a_r3_hist_follows : assert property (@(posedge clk) disable iff (!rst_n)
      rst_n && load |=> last_taken == $past(outcome));

endmodule

// File: rtl/gsel_dir_predictor.sv
module gsel_dir_predictor #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned ENTRIES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              solo_mode,
   input  logic [ADDR_W-1:0] pred_addr,
   output logic              pred_taken,
   input  logic              res_valid,
   input  logic [ADDR_W-1:0] res_addr,
   input  logic              res_taken
);
   import gsel_pkg::*;

   localparam int unsigned IDX_W  = $clog2(ENTRIES);
   localparam int unsigned IDX_LO = 2;
   localparam int unsigned IDX_HI = IDX_LO + IDX_W - 1;

   generate
      if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
         $error("ENTRIES must be a power of two of at least 2");
      end
      if (ADDR_W < IDX_HI + 1) begin : g_bad_addr
         $error("ADDR_W too narrow for the bank index");
      end
   endgenerate

   logic             hist_q;
   bank_e            bank_sel;
   logic [IDX_W-1:0] pred_idx;
   logic [IDX_W-1:0] res_idx;
   logic [NUM_BANKS-1:0] bank_rd;
   logic [NUM_BANKS-1:0] bank_we;

   assign pred_idx = pred_addr[IDX_HI:IDX_LO];
   assign res_idx  = res_addr[IDX_HI:IDX_LO];
   assign bank_sel = solo_mode ? BANK_AFTER_NT : bank_e'(hist_q);

   gsel_hist_bit u_hist (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (res_valid),
      .outcome    (res_taken),
      .last_taken (hist_q)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign bank_we[b] = res_valid && (int'(bank_sel) == b);

      gsel_bit_bank #(
         .ENTRIES (ENTRIES)
      ) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .rd_idx (pred_idx),
         .rd_bit (bank_rd[b]),
         .wr_en  (bank_we[b]),
         .wr_idx (res_idx),
         .wr_bit (res_taken)
      );
   end

   assign pred_taken = bank_rd[bank_sel];

   // R2: a lookup of the entry just written, through the same bank, returns that outcome
   a_r2_read_after_write : assert property (@(posedge clk) disable iff (!rst_n)
      rst_n && res_valid |=>
         ((pred_idx == $past(res_idx)) && (bank_sel == $past(bank_sel)))
            |-> (pred_taken == $past(res_taken)));

   // R9: in solo mode the bank-1 write strobe stays low
   a_r9_solo_bank0 : assert property (@(posedge clk) disable iff (!rst_n)
      solo_mode |-> !bank_we[1]);

endmodule

// File: tb/sim_gsel_dir_predictor.sv
module sim_gsel_dir_predictor;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              solo_mode = 1'b0;
   logic [ADDR_W-1:0] pred_addr = '0;
   logic              pred_taken;
   logic              res_valid = 1'b0;
   logic [ADDR_W-1:0] res_addr = '0;
   logic              res_taken = 1'b0;

   int n_vec = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gsel_dir_predictor #(.ADDR_W(ADDR_W), .ENTRIES(16)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .solo_mode  (solo_mode),
      .pred_addr  (pred_addr),
      .pred_taken (pred_taken),
      .res_valid  (res_valid),
      .res_addr   (res_addr),
      .res_taken  (res_taken)
   );

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; res_valid = 1'b0; solo_mode = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic resolve(input logic [ADDR_W-1:0] a, input logic t);
      @(negedge clk);
      res_addr = a; res_taken = t; res_valid = 1'b1;
      @(negedge clk);
      res_valid = 1'b0;
   endtask

   task automatic expect_pred(input logic [ADDR_W-1:0] a, input logic exp, input string req);
      pred_addr = a;
      #1;
      n_vec++;
      if (pred_taken !== exp) begin
         n_bad++;
         $display("FAIL %s addr=%h actual=%b expected=%b", req, a, pred_taken, exp);
      end
   endtask

   task automatic t_reset_state();
      do_reset();
      expect_pred(32'h0000_0000, 1'b0, "R1");
      expect_pred(32'h0000_0044, 1'b0, "R1");
      expect_pred(32'hFFFF_FFFC, 1'b0, "R1");
   endtask

   task automatic t_bank_select();
      do_reset();
      resolve(32'h44, 1'b1);            // hist 0: bank0[1]=1, hist->1
      expect_pred(32'h44, 1'b0, "R4");  // bank1[1] untouched (R5)
      resolve(32'h48, 1'b0);            // hist 1: bank1[2]=0, hist->0
      expect_pred(32'h44, 1'b1, "R2");  // hist back to 0 (R3)
      resolve(32'h4C, 1'b1);            // bank0[3]=1, hist->1
      expect_pred(32'h4C, 1'b0, "R6");  // update used old history
      resolve(32'h50, 1'b1);            // bank1[4]=1, hist stays 1
      expect_pred(32'h50, 1'b1, "R4");
      expect_pred(32'h4C, 1'b0, "R5");
   endtask

   task automatic t_alias();
      do_reset();
      resolve(32'h04, 1'b1);            // bank0[1]=1, hist->1
      resolve(32'h100, 1'b0);           // bank1[0]=0, hist->0
      expect_pred(32'h07, 1'b1, "R7");
      expect_pred(32'h44, 1'b1, "R7");
      expect_pred(32'h08, 1'b0, "R7");
   endtask

   task automatic t_valid_low();
      do_reset();
      resolve(32'h0C, 1'b1);            // bank0[3]=1, hist->1
      resolve(32'h10, 1'b0);            // bank1[4]=0, hist->0
      @(negedge clk);
      res_addr = 32'h04; res_taken = 1'b1; res_valid = 1'b0;
      repeat (3) @(negedge clk);
      expect_pred(32'h0C, 1'b1, "R8");  // history not loaded
      expect_pred(32'h04, 1'b0, "R8");  // bank not written
   endtask

   task automatic t_solo();
      do_reset();
      solo_mode = 1'b1;
      resolve(32'h04, 1'b1);            // bank0[1]=1, hist->1
      expect_pred(32'h04, 1'b1, "R9");
      resolve(32'h08, 1'b1);            // bank0[2]=1 despite hist 1
      solo_mode = 1'b0;
      expect_pred(32'h08, 1'b0, "R9");  // bank1[2] still 0
      expect_pred(32'h04, 1'b0, "R9");  // history was still recorded
      resolve(32'h0C, 1'b0);            // bank1[3]=0, hist->0
      expect_pred(32'h08, 1'b1, "R9");
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_vec++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      t_reset_state();
      t_bank_select();
      t_alias();
      t_valid_low();
      t_solo();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule